// File: doc/BRIEF.md
# Serial Packed Decimal Adder-Subtractor

This block adds or subtracts two signed packed-decimal numbers that sit in a byte-wide memory. It reaches that memory through one synchronous port. A read returns its data in the cycle after the request. The unit makes at most one access per clock. A one-cycle start pulse supplies four things: the operation, a length byte holding two independent field lengths, and two addresses. Each address points at the low-order (rightmost) byte of its field.

The first operand is overwritten in place with the result, working from the least significant digit upward. When the effective signs differ, the unit takes the magnitude difference with a nines-complement pass. If that difference comes out negative, a second pass recomplements the result. The unit writes the sign byte last. A single-cycle done pulse then accompanies a 2-bit condition code.

A field of N bytes holds 2N-1 digits. The rightmost byte carries the least significant digit in bits 7:4 and the sign in bits 3:0. Every other byte carries two digits, with the more significant digit in bits 7:4.

Top module: `pdec_adder`

## Requirements
- R1: Only the bytes from addr1_i-L1+1 to addr1_i are written; the byte just below the field keeps its value.
- R2: len_i[7:4] holds L1-1 and len_i[3:0] holds L2-1, so each operand is 1 to 16 bytes long and a field holds 2L-1 digits.
- R3: A sign nibble of 0xB or 0xD reads as negative; 0xA, 0xC, 0xE and 0xF read as positive.
- R4: A non-overflowing, non-zero result gets sign nibble 0xC when positive and 0xD when negative, in bits 3:0 of the byte at addr1_i.
- R5: A second operand longer than the first contributes only its low-order 2L1-1 digits; a shorter one acts as if padded with leading zeros.
- R6: When the magnitude sum does not fit in 2L1-1 digits, the truncated low-order digits are written, the original sign nibble of the first operand is kept, and cc_o = 0.
- R7: Without overflow, cc_o is 1 for a negative result, 2 for zero and 3 for a positive result.
- R8: sub_i = 1 computes first minus second (sub_i = 0 adds), and the magnitude is correct whichever operand is larger.
- R9: A zero result is always written with sign 0xC and cc_o = 2, including sums of negative operands and a field subtracted from itself.
- R10: start_i is taken only while busy_o is low; a write is always also a request; done_o is high for exactly one cycle, and busy_o falls in the cycle after it.
- R11: A second-operand field that does not overlap the first is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| len_i | input | 8 | {L1-1, L2-1} |
| addr1_i | input | 16 | Rightmost byte of the first operand / result |
| addr2_i | input | 16 | Rightmost byte of the second operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after a read request |

## Verification
Overflow detection and zero detection are both resolved in the same evaluation cycle. A carry out of the top digit can leave every written digit at zero. Cases such as -999 + -1 in a two-byte field provoke this, and they must give cc 0 with the old sign nibble rather than cc 2 with 0xC. The recomplement pass and the zero check meet as well: a field subtracted from itself at the same address, and mixed-sign sums of equal magnitude, must end at 0xC and cc 2 with no negative zero.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [1:0] {
    ALU_ADD    = 2'd0,
    ALU_SUB    = 2'd1,
    ALU_RECOMP = 2'd2
  } alu_mode_e;

  localparam logic [1:0] CC_OVF  = 2'd0;
  localparam logic [1:0] CC_NEG  = 2'd1;
  localparam logic [1:0] CC_ZERO = 2'd2;
  localparam logic [1:0] CC_POS  = 2'd3;

  localparam logic [3:0] SGN_POS = 4'hC;
  localparam logic [3:0] SGN_NEG = 4'hD;

  function automatic logic sign_is_neg(logic [3:0] s);
    return (s == 4'hB) || (s == 4'hD);
  endfunction

endpackage

// File: rtl/pdec_digit_slice.sv
module pdec_digit_slice
  import pdec_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  input  alu_mode_e  mode_i,
  output logic [3:0] sum_o,
  output logic       cout_o
);

  logic [3:0] x, y;
  logic [4:0] raw, adj;
  logic       wrap;

  always_comb begin
    x = (mode_i == ALU_RECOMP) ? 4'd9 - a_i : a_i;
    unique case (mode_i)
      ALU_ADD: y = b_i;
      ALU_SUB: y = 4'd9 - b_i;
      default: y = 4'd0;
    endcase
    raw  = {1'b0, x} + {1'b0, y} + {4'd0, cin_i};
    adj  = raw - 5'd10;
    wrap = (raw >= 5'd10);
  end

  assign sum_o  = wrap ? adj[3:0] : raw[3:0];
  assign cout_o = wrap;

endmodule

// File: rtl/pdec_byte_alu.sv
module pdec_byte_alu
  import pdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  alu_mode_e         mode_i,
  input  logic              sign_byte_i,  // nibble 0 is a sign, not a digit
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              nz_o
);

  localparam int NDIG = DATA_W / 4;

  logic [NDIG:0]   carry;
  logic [NDIG-1:0] slice_cout;
  logic [NDIG-1:0] dig_nz;
  logic [3:0]      slice_sum [NDIG];

  assign carry[0] = cin_i;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    pdec_digit_slice i_slice (
      .a_i   (a_i[4*k +: 4]),
      .b_i   (b_i[4*k +: 4]),
      .cin_i (carry[k]),
      .mode_i(mode_i),
      .sum_o (slice_sum[k]),
      .cout_o(slice_cout[k])
    );
    if (k == 0) begin : g_lsd
      assign carry[1]    = sign_byte_i ? carry[0] : slice_cout[0];
      assign sum_o[3:0]  = sign_byte_i ? a_i[3:0] : slice_sum[0];
      assign dig_nz[0]   = !sign_byte_i && (slice_sum[0] != 4'd0);
    end else begin : g_msd
      assign carry[k+1]    = slice_cout[k];
      assign sum_o[4*k +: 4] = slice_sum[k];
      assign dig_nz[k]     = (slice_sum[k] != 4'd0);
    end
  end

  assign cout_o = carry[NDIG];
  assign nz_o   = |dig_nz;

endmodule

// File: rtl/pdec_sign_logic.sv
module pdec_sign_logic
  import pdec_pkg::*;
(
  input  logic [3:0] s1_i,     // first operand's original sign nibble
  input  logic [3:0] s2_i,     // second operand's sign nibble
  input  logic       sub_i,
  input  logic       ovf_i,
  input  logic       zero_i,
  input  logic       neg_i,
  output logic       neg1_o,
  output logic       eff_sub_o,
  output logic [3:0] sign_o,
  output logic [1:0] cc_o
);

  logic neg2_eff;

  assign neg1_o    = sign_is_neg(s1_i);
  assign neg2_eff  = sign_is_neg(s2_i) ^ sub_i;
  assign eff_sub_o = neg1_o ^ neg2_eff;

  always_comb begin
    if (ovf_i) begin
      sign_o = s1_i;
      cc_o   = CC_OVF;
    end else if (zero_i) begin
      sign_o = SGN_POS;
      cc_o   = CC_ZERO;
    end else if (neg_i) begin
      sign_o = SGN_NEG;
      cc_o   = CC_NEG;
    end else begin
      sign_o = SGN_POS;
      cc_o   = CC_POS;
    end
  end

endmodule

// File: rtl/pdec_adder.sv
module pdec_adder
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 sub_i,
  input  logic [2*LEN_W-1:0]   len_i,
  input  logic [ADDR_W-1:0]    addr1_i,
  input  logic [ADDR_W-1:0]    addr2_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           cc_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i
);

  localparam int LL_W = 2 * LEN_W;
  localparam int HI_W = DATA_W - 4;

  typedef enum logic [3:0] {
    S_IDLE, S_RS1, S_RS2, S_SGN,
    S_ARD1, S_ARD2, S_AWR, S_EVAL,
    S_R0, S_RRD, S_RWR, S_FIN, S_DONE
  } state_e;

  state_e              state_q;
  logic [ADDR_W-1:0]   a1_q, a2_q;
  logic [LEN_W-1:0]    len1_q, len2_q, idx_q;
  logic                sub_q, eff_sub_q, neg1_q;
  logic                use2_q, carry_q, nz_q;
  logic                ovf_q, zero_q, neg_q;
  logic [3:0]          old_sign_q;
  logic [HI_W-1:0]     d0_q;
  logic [DATA_W-1:0]   op1_q;
  logic [1:0]          cc_q;

  logic [ADDR_W-1:0]   addr_a1, addr_a2;
  logic                use2_now;

  assign addr_a1  = a1_q - ADDR_W'(idx_q);
  assign addr_a2  = a2_q - ADDR_W'(idx_q);
  assign use2_now = (idx_q <= len2_q);

  // Byte ALU operand steering
  logic [DATA_W-1:0] alu_a, alu_b, alu_sum;
  logic              alu_cin, alu_sbyte, alu_cout, alu_nz;
  alu_mode_e         alu_mode;

  always_comb begin
    alu_a     = mem_rdata_i;
    alu_b     = '0;
    alu_cin   = carry_q;
    alu_mode  = ALU_RECOMP;
    alu_sbyte = 1'b0;
    unique case (state_q)
      S_AWR: begin
        alu_a     = op1_q;
        alu_b     = use2_q ? mem_rdata_i : '0;
        alu_mode  = eff_sub_q ? ALU_SUB : ALU_ADD;
        alu_sbyte = (idx_q == '0);
      end
      S_R0: begin
        alu_a     = {d0_q, 4'h0};
        alu_sbyte = 1'b1;
      end
      default: ;
    endcase
  end

  pdec_byte_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i        (alu_a),
    .b_i        (alu_b),
    .cin_i      (alu_cin),
    .mode_i     (alu_mode),
    .sign_byte_i(alu_sbyte),
    .sum_o      (alu_sum),
    .cout_o     (alu_cout),
    .nz_o       (alu_nz)
  );

  logic       neg1_w, eff_sub_w;
  logic [3:0] sign_w;
  logic [1:0] cc_w;

  pdec_sign_logic i_sign (
    .s1_i     (old_sign_q),
    .s2_i     (mem_rdata_i[3:0]),
    .sub_i    (sub_q),
    .ovf_i    (ovf_q),
    .zero_i   (zero_q),
    .neg_i    (neg_q),
    .neg1_o   (neg1_w),
    .eff_sub_o(eff_sub_w),
    .sign_o   (sign_w),
    .cc_o     (cc_w)
  );

  // Memory port, one access per cycle
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RS1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = a1_q;
      end
      S_RS2: begin
        mem_req_o  = 1'b1;
        mem_addr_o = a2_q;
      end
      S_ARD1, S_RRD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = addr_a1;
      end
      S_ARD2: begin
        mem_req_o  = use2_now;
        mem_addr_o = addr_a2;
      end
      S_AWR: begin
        // sign byte is deferred to S_FIN
        mem_req_o   = (idx_q != '0);
        mem_we_o    = (idx_q != '0);
        mem_addr_o  = addr_a1;
        mem_wdata_o = alu_sum;
      end
      S_RWR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = addr_a1;
        mem_wdata_o = alu_sum;
      end
      S_FIN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = a1_q;
        mem_wdata_o = {d0_q, sign_w};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      a1_q       <= '0;
      a2_q       <= '0;
      len1_q     <= '0;
      len2_q     <= '0;
      idx_q      <= '0;
      sub_q      <= 1'b0;
      eff_sub_q  <= 1'b0;
      neg1_q     <= 1'b0;
      use2_q     <= 1'b0;
      carry_q    <= 1'b0;
      nz_q       <= 1'b0;
      ovf_q      <= 1'b0;
      zero_q     <= 1'b0;
      neg_q      <= 1'b0;
      old_sign_q <= '0;
      d0_q       <= '0;
      op1_q      <= '0;
      cc_q       <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          a1_q    <= addr1_i;
          a2_q    <= addr2_i;
          len1_q  <= len_i[LL_W-1:LEN_W];
          len2_q  <= len_i[LEN_W-1:0];
          sub_q   <= sub_i;
          state_q <= S_RS1;
        end
        S_RS1: state_q <= S_RS2;
        S_RS2: begin
          old_sign_q <= mem_rdata_i[3:0];
          state_q    <= S_SGN;
        end
        S_SGN: begin
          eff_sub_q <= eff_sub_w;
          neg1_q    <= neg1_w;
          carry_q   <= eff_sub_w;  // tens complement adds one
          nz_q      <= 1'b0;
          idx_q     <= '0;
          state_q   <= S_ARD1;
        end
        S_ARD1: state_q <= S_ARD2;
        S_ARD2: begin
          op1_q   <= mem_rdata_i;
          use2_q  <= use2_now;
          state_q <= S_AWR;
        end
        S_AWR: begin
          carry_q <= alu_cout;
          nz_q    <= nz_q | alu_nz;
          if (idx_q == '0) d0_q <= alu_sum[DATA_W-1:4];
          if (idx_q == len1_q) begin
            state_q <= S_EVAL;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_ARD1;
          end
        end
        S_EVAL: begin
          if (!eff_sub_q) begin
            ovf_q   <= carry_q;
            neg_q   <= neg1_q;
            zero_q  <= !nz_q;
            state_q <= S_FIN;
          end else if (carry_q) begin
            ovf_q   <= 1'b0;
            neg_q   <= neg1_q;
            zero_q  <= !nz_q;
            state_q <= S_FIN;
          end else begin
            // second magnitude was larger: recomplement
            ovf_q   <= 1'b0;
            neg_q   <= !neg1_q;
            zero_q  <= 1'b0;
            carry_q <= 1'b1;
            idx_q   <= '0;
            state_q <= S_R0;
          end
        end
        S_R0: begin
          d0_q    <= alu_sum[DATA_W-1:4];
          carry_q <= alu_cout;
          if (len1_q == '0) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= LEN_W'(1);
            state_q <= S_RRD;
          end
        end
        S_RRD: state_q <= S_RWR;
        S_RWR: begin
          carry_q <= alu_cout;
          if (idx_q == len1_q) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_RRD;
          end
        end
        S_FIN: begin
          cc_q    <= cc_w;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign cc_o   = cc_q;

endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LEN_W-1:0]  len1_i,
  input logic [ADDR_W-1:0] addr1_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        cc_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        wnib_i
);

  logic [ADDR_W-1:0] a1_l;
  logic [LEN_W-1:0]  l1_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_l <= '0;
      l1_l <= '0;
    end else if (start_i && !busy_o) begin
      a1_l <= addr1_i;
      l1_l <= len1_i;
    end
  end

  assert_write_in_field_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((a1_l - mem_addr_o) <= ADDR_W'(l1_l)));

  assert_we_has_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_zero_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == 2'd2) |-> ($past(mem_we_o) && $past(wnib_i) == 4'hC));

  assert_neg_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == 2'd1) |-> ($past(mem_we_o) && $past(wnib_i) == 4'hD));

  assert_pos_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == 2'd3) |-> ($past(mem_we_o) && $past(wnib_i) == 4'hC));

endmodule

bind pdec_adder pdec_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_pdec_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .len1_i    (len_i[2*LEN_W-1:LEN_W]),
  .addr1_i   (addr1_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cc_o      (cc_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .wnib_i    (mem_wdata_o[3:0])
);

// File: tb/test_pdec_adder.sv
module test_pdec_adder;

  localparam int CLK_PERIOD = 10;
  localparam int A1 = 100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sub_i = 1'b0;
  logic [7:0]  len_i = '0;
  logic [15:0] addr1_i = '0;
  logic [15:0] addr2_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [1:0]  cc_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  logic [7:0]  mem [0:1023];
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [7:0]  pre_data = '0;

  int n_chk = 0, n_fail = 0, n_sent = 0, n_done = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdec_adder i_pdec_adder (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sub_i(sub_i),
    .len_i(len_i), .addr1_i(addr1_i), .addr2_i(addr2_i),
    .busy_o(busy_o), .done_o(done_o), .cc_o(cc_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
      else mem_rdata_i <= mem[mem_addr_o[9:0]];
    end
  end

  typedef struct {
    int           a1, l1, a2, l2;
    logic [127:0] exp_v, op2_v;
    logic [1:0]   cc;
    bit           chk2;
    string        tag;
  } item_t;
  item_t sb_q[$];

  task automatic check(input bit ok, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [3:0] dig(input logic [127:0] v, input int k);
    int b;
    b = (k + 1) / 2;
    return (k % 2 == 1) ? v[8*b +: 4] : v[8*b+4 +: 4];
  endfunction

  // reference: sign-magnitude with explicit magnitude compare
  task automatic ref_model(input bit sub, input int l1, input int l2,
                           input logic [127:0] v1, input logic [127:0] v2,
                           output logic [127:0] ev, output logic [1:0] cc);
    int n, n2, c, t;
    int da[31], db[31], r[31];
    bit neg1, neg2, ovf, rneg, zero, a_ge;
    logic [3:0] sg;
    n = 2*l1 - 1;
    n2 = 2*l2 - 1;
    neg1 = (v1[3:0] == 4'hB) || (v1[3:0] == 4'hD);
    neg2 = ((v2[3:0] == 4'hB) || (v2[3:0] == 4'hD)) ^ sub;
    for (int k = 0; k < 31; k++) begin
      da[k] = (k < n) ? int'(dig(v1, k)) : 0;
      db[k] = (k < n && k < n2) ? int'(dig(v2, k)) : 0;
      r[k] = 0;
    end
    ovf = 0;
    if (neg1 == neg2) begin
      c = 0;
      for (int k = 0; k < n; k++) begin
        t = da[k] + db[k] + c;
        r[k] = t % 10;
        c = t / 10;
      end
      ovf = (c != 0);
      rneg = neg1;
    end else begin
      a_ge = 1;
      for (int k = n - 1; k >= 0; k--) begin
        if (da[k] != db[k]) begin
          a_ge = da[k] > db[k];
          break;
        end
      end
      c = 0;
      for (int k = 0; k < n; k++) begin
        t = a_ge ? da[k] - db[k] - c : db[k] - da[k] - c;
        if (t < 0) begin t += 10; c = 1; end else c = 0;
        r[k] = t;
      end
      rneg = a_ge ? neg1 : neg2;
    end
    zero = 1;
    for (int k = 0; k < n; k++) if (r[k] != 0) zero = 0;
    sg = ovf ? v1[3:0] : ((zero || !rneg) ? 4'hC : 4'hD);
    cc = ovf ? 2'd0 : (zero ? 2'd2 : (rneg ? 2'd1 : 2'd3));
    ev = '0;
    ev[7:0] = {4'(r[0]), sg};
    for (int j = 1; j < l1; j++) ev[8*j +: 8] = {4'(r[2*j]), 4'(r[2*j-1])};
  endtask

  task automatic put(input int a, input logic [7:0] d);
    pre_we = 1'b1;
    pre_addr = 10'(a);
    pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // driver: preload, push expectation, start, wait
  task automatic run_op(input string tag, input bit sub, input int l1, input int l2,
                        input int a2, input logic [127:0] v1, input logic [127:0] v2);
    item_t it;
    @(negedge clk);
    for (int i = 0; i < l1; i++) put(A1 - i, v1[8*i +: 8]);
    if (a2 != A1) for (int i = 0; i < l2; i++) put(a2 - i, v2[8*i +: 8]);
    put(A1 - l1, 8'h5A);
    it.a1 = A1; it.l1 = l1; it.a2 = a2; it.l2 = l2;
    it.op2_v = v2; it.chk2 = (a2 != A1); it.tag = tag;
    ref_model(sub, l1, l2, v1, v2, it.exp_v, it.cc);
    sb_q.push_back(it);
    n_sent++;
    sub_i = sub;
    len_i = {4'(l1 - 1), 4'(l2 - 1)};
    addr1_i = 16'(A1);
    addr2_i = 16'(a2);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (n_done != n_sent) @(negedge clk);
    @(negedge clk);
    check(!done_o && !busy_o, {tag, " R10 done single cycle, idle after"}, {done_o, busy_o}, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      item_t it;
      logic [127:0] got;
      if (sb_q.size() == 0) begin
        check(0, "R10 done without request", 1, 0);
      end else begin
        it = sb_q.pop_front();
        check(cc_o == it.cc, {it.tag, " R7 cc"}, cc_o, it.cc);
        got = '0;
        for (int i = 0; i < it.l1; i++) got[8*i +: 8] = mem[it.a1 - i];
        check(got == it.exp_v, {it.tag, " result field"}, got, it.exp_v);
        check(mem[it.a1 - it.l1] == 8'h5A, {it.tag, " R1 guard byte"}, mem[it.a1 - it.l1], 8'h5A);
        if (it.chk2) begin
          got = '0;
          for (int i = 0; i < it.l2; i++) got[8*i +: 8] = mem[it.a2 - i];
          check(got == (it.op2_v & ((128'd1 << (8*it.l2)) - 1)), {it.tag, " R11 op2 untouched"},
                got, it.op2_v);
        end
      end
      n_done++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done_o, "R10 reset done_o", done_o, 0);
    check(!busy_o, "R10 reset busy_o", busy_o, 0);
    check(!mem_req_o, "R10 reset mem_req_o", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    run_op("R7 add positive",            0, 2, 2, 300, 128'h123C, 128'h456C);
    run_op("R8 sub recomplement",        1, 2, 2, 300, 128'h123C, 128'h456C);
    run_op("R8 sub direct",              1, 2, 2, 300, 128'h456C, 128'h123C);
    run_op("R3 neg B plus pos A",        0, 2, 2, 300, 128'h123B, 128'h100A);
    run_op("R4 pos E plus pos F",        0, 2, 2, 300, 128'h050E, 128'h020F);
    run_op("R3 sub of negative D",       1, 2, 2, 300, 128'h005C, 128'h009D);
    run_op("R6 overflow keeps F",        0, 1, 1, 300, 128'h5F,   128'h7C);
    run_op("R6 overflow zero digits",    0, 2, 2, 300, 128'h999D, 128'h001D);
    run_op("R5 op2 longer",              0, 2, 4, 300, 128'h001C, 128'h9876543C);
    run_op("R5 op2 shorter",             0, 3, 1, 300, 128'h12345C, 128'h9C);
    run_op("R9 mixed zero",              0, 2, 2, 300, 128'h123D, 128'h123C);
    run_op("R9 negative zero sum",       0, 2, 2, 300, 128'h000D, 128'h000B);
    run_op("R9 self subtract",           1, 2, 2, A1,  128'h987C, 128'h987C);
    run_op("R2 max length",              1, 16, 16, 300,
           128'h1234567890123456789012345678901C, 128'h9876543210987654321098765432109D);
    run_op("R2 asymmetric lengths",      1, 4, 2, 300, 128'h0000100C, 128'h001C);
    for (int k = 0; k < 8; k++) begin
      logic [127:0] v1, v2;
      logic [3:0] sgn [6];
      int l1, l2;
      sgn = '{4'hC, 4'hD, 4'hA, 4'hB, 4'hE, 4'hF};
      l1 = (k * 5) % 16 + 1;
      l2 = (k * 3 + 2) % 16 + 1;
      v1 = '0;
      v2 = '0;
      for (int i = 0; i < 16; i++) begin
        v1[8*i +: 8] = {4'((k + i * 3) % 10), 4'((k * 7 + i) % 10)};
        v2[8*i +: 8] = {4'((k * 2 + i) % 10), 4'((i * 7 + 3) % 10)};
      end
      v1[3:0] = sgn[k % 6];
      v2[3:0] = sgn[(k + 3) % 6];
      run_op("R8 sweep", k[0], l1, l2, 300, v1, v2);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule